// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets a clocked host read and write an external asynchronous static RAM with 512K locations of 8 bits each. The host makes a request through a handshake. It presents an address, write data and a write flag while `ready` is high. A read returns its byte on `rdata`, and `rvalid` marks it with a one-cycle pulse.

On the memory side the block drives three active-low strobes (select, output enable and write enable) and the address. The bidirectional data pins appear as three separate signals: an output value, an input value and an output-enable.

Every timing interval of the memory is a parameter given in nanoseconds. The block converts each one to a whole number of clock cycles, rounding up, and uses at least one cycle. The controller does the following:

- It holds the address still while the memory is selected.
- It drives write data one cycle before the write strobe falls.
- It keeps output enable high during a write.
- When a write follows a read, it waits out the memory's output-disable time before it drives the data bus.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, the strobes `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rvalid` is 0 and `ready` is 1.
- R2: A read is accepted on a clock edge where `req` is 1, `wr` is 0 and `ready` is 1. From the next cycle, `mem_cs_n` and `mem_oe_n` are 0, `mem_we_n` is 1 and `mem_addr` equals the request address, for RD_CYC cycles (3 by default). The byte on `mem_dq_i` in the last of those cycles appears on `rdata`, with `rvalid` at 1 for exactly one cycle, starting RD_CYC cycles after the accepting edge.
- R3: A write runs as follows:
  - A setup cycle: `mem_cs_n` is 0, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 1, and `mem_dq_o` and `mem_addr` hold the request.
  - WP_CYC cycles (2 by default) with `mem_we_n` at 0.
  - One cycle with both strobes at 1 while the data is still driven.
  - Then `mem_dq_oe` returns to 0.
- R4: `mem_oe_n` is 1 whenever `mem_we_n` is 0 and whenever `mem_dq_oe` is 1. The controller never drives the bus while the memory may be driving it.
- R5: `mem_addr` does not change between two consecutive cycles in which `mem_cs_n` is 0.
- R6: When a write follows a read, `mem_cs_n` stays 1 and `mem_dq_oe` stays 0 for HZ_CYC cycles (2 by default) after acceptance, before the setup cycle.
- R7: `ready` is 0 from the cycle after acceptance until the cycle after the strobes return to 1. A `req` seen while `ready` is 0 starts no memory cycle.
- R8: A byte written to an address is returned by a later read of that address.
- R9: When a write follows a write, or is the first access after reset, its setup cycle begins in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when `ready` is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Host word address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | Controller idle and able to accept |
| rdata | output | 8 | Read result |
| rvalid | output | 1 | One-cycle pulse marking `rdata` |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_i | input | 8 | Data received from the memory |
| mem_dq_oe | output | 1 | Controller drives the data pins when 1 |

## Verification
A state machine that leaves a phase one cycle early or late changes the strobe widths, and the bench compares those widths cycle by cycle on the next falling edge. The memory model returns the real byte only after the access time. A read that samples too early therefore returns a wrong `rdata` in the same cycle as `rvalid`.

A lost read/write history shows up in two ways. The controller may skip the turnaround and drive the bus within two cycles of output enable rising. Or it may insert the turnaround where none is due. Both are seen at the first cycle after acceptance.

A bad address or data latch appears as a wrong byte on readback.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WTURN, ST_WSET, ST_WPULSE, ST_DONE
  } asram_st_t;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_phase_cnt.sv
`timescale 1ns/1ps
module asram_phase_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_rd_capture.sv
`timescale 1ns/1ps
module asram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= dq_i;
    end
  end
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2,
  parameter int RD_CYC = 3,
  parameter int WP_CYC = 2,
  parameter int HZ_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cnt_zero,
  output logic              ready,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] maddr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              cap
);
  asram_st_t st;
  logic      last_rd;   // previous access left the memory driving the bus
  logic      accept;

  assign accept = (st == ST_IDLE) && req && ready;
  assign cap    = (st == ST_RD) && cnt_zero;

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (st == ST_WSET) begin
      cnt_load = 1'b1;
      cnt_val  = CNT_W'(WP_CYC - 1);
    end else if (accept) begin
      cnt_load = 1'b1;
      cnt_val  = wr ? CNT_W'(HZ_CYC - 1) : CNT_W'(RD_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ready   <= 1'b1;
      cs_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      maddr   <= '0;
      dq_o    <= '0;
      dq_oe   <= 1'b0;
      last_rd <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          dq_oe <= 1'b0;
          if (accept) begin
            ready <= 1'b0;
            maddr <= addr;
            if (wr) begin
              dq_o <= wdata;
              if (last_rd) begin
                st <= ST_WTURN;
              end else begin
                st    <= ST_WSET;
                cs_n  <= 1'b0;
                dq_oe <= 1'b1;
              end
            end else begin
              st   <= ST_RD;
              cs_n <= 1'b0;
              oe_n <= 1'b0;
            end
          end
        end
        ST_WTURN: begin
          if (cnt_zero) begin
            st    <= ST_WSET;
            cs_n  <= 1'b0;
            dq_oe <= 1'b1;
          end
        end
        ST_WSET: begin
          we_n <= 1'b0;
          st   <= ST_WPULSE;
        end
        ST_WPULSE: begin
          if (cnt_zero) begin
            we_n    <= 1'b1;
            cs_n    <= 1'b1;
            last_rd <= 1'b0;
            st      <= ST_DONE;
          end
        end
        ST_RD: begin
          if (cnt_zero) begin
            cs_n    <= 1'b1;
            oe_n    <= 1'b1;
            last_rd <= 1'b1;
            st      <= ST_DONE;
          end
        end
        ST_DONE: begin
          ready <= 1'b1;
          dq_oe <= 1'b0;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 4,
  parameter int T_RC_NS = 12,
  parameter int T_WP_NS = 8,
  parameter int T_WC_NS = 12,
  parameter int T_HZ_NS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);
  localparam int RD_CYC  = ns2cyc(T_RC_NS, CLK_NS);
  // a write spans setup + pulse + end; the pulse also stretches to meet the cycle time
  localparam int WP_CYC  = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS) - 2);
  localparam int HZ_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = imax(RD_CYC, imax(WP_CYC, HZ_CYC));
  localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic             cap;

  asram_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .HZ_CYC (HZ_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .wr       (wr),
    .addr     (addr),
    .wdata    (wdata),
    .cnt_zero (cnt_zero),
    .ready    (ready),
    .cs_n     (mem_cs_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .maddr    (mem_addr),
    .dq_o     (mem_dq_o),
    .dq_oe    (mem_dq_oe),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .cap      (cap)
  );

  asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap    (cap),
    .dq_i   (mem_dq_i),
    .rdata  (rdata),
    .rvalid (rvalid)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int CLK_NS  = 4,
  parameter int T_HZ_NS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rvalid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  localparam int HZ_CYC = ns2cyc(T_HZ_NS, CLK_NS);

  // cycles since the memory's output enable was last released
  int hz_cnt;
  always_ff @(posedge clk) begin
    if (rst)                 hz_cnt <= HZ_CYC;
    else if (!mem_oe_n)      hz_cnt <= 0;
    else if (hz_cnt < HZ_CYC) hz_cnt <= hz_cnt + 1;
  end

  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> (mem_addr == $past(mem_addr)));

  assert_data_before_we_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  assert_busy_while_active_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !ready);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (hz_cnt >= HZ_CYC));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .CLK_NS  (CLK_NS),
  .T_HZ_NS (T_HZ_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .rvalid    (rvalid),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int WP = 2;   // write pulse cycles at 4 ns
  localparam int HZ = 2;   // turnaround cycles at 4 ns

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid;
  logic [DW-1:0] rdata;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_dq_oe(mem_dq_oe)
  );

  // memory model: 256 locations on the low address byte; data valid only after access time
  logic [DW-1:0] mem [0:255];
  int rd_age = 0;
  logic rd_on;
  assign rd_on = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = (rd_on && rd_age >= 2) ? mem[mem_addr[7:0]] : 8'hEE;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dq_o;
    rd_age <= rd_on ? rd_age + 1 : 0;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // bus contention watch, R4
  always @(negedge clk)
    if (!rst && mem_dq_oe && rd_on) chk(1'b0, "R4 contention", 1, 0);

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    issue(1'b0, a, 8'h00);
    chk(!mem_cs_n && !mem_oe_n && mem_we_n, "R2 read strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b001);
    chk(mem_addr == a, "R2 read addr", mem_addr, a);
    chk(!ready, "R7 busy in read", ready, 0);
    repeat (2) @(negedge clk);
    chk(!rvalid, "R2 rvalid not early", rvalid, 0);
    @(negedge clk);
    chk(rvalid, "R2 rvalid", rvalid, 1);
    chk(rdata == exp, "R2 R8 rdata", rdata, exp);
    chk(mem_cs_n && mem_oe_n, "R2 strobes released", {mem_cs_n, mem_oe_n}, 2'b11);
    @(negedge clk);
    chk(!rvalid, "R2 rvalid one cycle", rvalid, 0);
    chk(ready, "R7 ready back", ready, 1);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int turn);
    issue(1'b1, a, d);
    for (int i = 0; i < turn; i++) begin
      chk(mem_cs_n && !mem_dq_oe, "R6 turnaround idle", {mem_cs_n, mem_dq_oe}, 2'b10);
      @(negedge clk);
    end
    chk(!mem_cs_n && mem_we_n && mem_oe_n && mem_dq_oe, turn == 0 ? "R9 R3 setup" : "R3 setup",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0111);
    chk(mem_dq_o == d && mem_addr == a, "R3 setup data/addr", mem_dq_o, d);
    for (int i = 0; i < WP; i++) begin
      @(negedge clk);
      chk(!mem_we_n && mem_oe_n && !mem_cs_n, "R3 R4 write pulse", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b010);
    end
    @(negedge clk);
    chk(mem_we_n && mem_cs_n && mem_dq_oe, "R3 data hold", {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b111);
    chk(!ready, "R7 busy at end", ready, 0);
    @(negedge clk);
    chk(!mem_dq_oe && ready, "R3 R7 release", {mem_dq_oe, ready}, 2'b01);
  endtask

  // request during a busy read must start nothing
  task automatic busy_ignore();
    issue(1'b0, 19'h00012, 8'h00);
    req = 1'b1; wr = 1'b1; addr = 19'h00033; wdata = 8'h55;
    repeat (3) @(negedge clk);
    req = 1'b0;
    chk(rvalid && rdata == 8'h5A, "R7 read unaffected", rdata, 8'h5A);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(mem_cs_n && !mem_dq_oe, "R7 ignored req", {mem_cs_n, mem_dq_oe}, 2'b10);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rvalid && ready,
        "R1 in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rvalid, ready}, 6'b111001);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rvalid && ready,
        "R1 after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rvalid, ready}, 6'b111001);
    do_write(19'h00012, 8'h5A, 0);
    do_write(19'h7FFFF, 8'hC3, 0);
    do_read(19'h00012, 8'h5A);
    do_write(19'h00100, 8'h81, HZ);
    do_read(19'h7FFFF, 8'hC3);
    do_read(19'h00100, 8'h81);
    busy_ignore();
    do_read(19'h00033, 8'h00);
    do_write(19'h00033, 8'hFF, HZ);
    do_write(19'h00012, 8'h00, 0);
    do_read(19'h00033, 8'hFF);
    do_read(19'h00012, 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule